// File: doc/BRIEF.md
# Armed Single-Shot Frame Grabber with Serial Dump

This controller takes one snapshot of a raw video sample stream and then plays it back over a byte-wide serial transmit path. Activity on the serial receive line arms it. Any level change counts, and no character framing is decoded. Once armed, the controller waits for the next rising edge of the frame sync. It then writes incoming samples into an external buffer as one flat sequence, with no notion of lines or columns, until every buffer location holds a sample.

When the buffer is full, the controller reads it back from location 0 upward. It presents each byte to a transmitter through a valid/ready handshake. It returns to rest after the last byte is taken. Both asynchronous inputs pass through two-flop synchronisers before their edges are detected. The buffer has one write port and one read port with one cycle of read latency. Both are outside the block.

Top module: `frame_grab_ctrl`

## Requirements
- R1: After reset the controller is at rest: `buf_we_o`, `buf_re_o` and `tx_valid_o` are low and both buffer addresses are 0, whatever `smp_en_i` does.
- R2: The receive line and the frame sync each pass through two synchronising flops before edge detection. A frame-sync rise driven before clock edge k starts capture at edge k+2, so the first write strobe can appear in the cycle after edge k+2 and not before.
- R3: A rising or a falling transition of `rxd_i` while at rest arms the controller. Arming alone never causes a write.
- R4: Frame-sync edges while at rest cause no capture. A falling frame-sync edge while armed causes no capture. Only a rising frame-sync edge while armed starts capture.
- R5: During capture, each cycle with `smp_en_i` high writes `smp_i` with `buf_we_o` high at an address that starts at 0 and increases by one per write. A cycle with `smp_en_i` low writes nothing and holds the address.
- R6: After exactly 2^ADDR_W writes, capture ends. No further write strobe occurs during the dump, even with `smp_en_i` high.
- R7: Transitions on `rxd_i` during capture or dump are ignored and do not re-arm the controller. A frame-sync edge after the dump completes therefore causes no capture.
- R8: During the dump, the controller issues `buf_re_o` at `buf_raddr_o`. The returned word appears on `tx_byte_o` with `tx_valid_o` high one cycle later. Byte and address hold until `tx_ready_i` is high, and the read address advances only on an accepted byte.
- R9: Acceptance of the byte from the last address returns the controller to rest: `tx_valid_o` and `buf_re_o` go low. A new arming then yields a new complete capture and dump.
- R10: The dumped bytes are exactly the captured samples, in address order 0 to 2^ADDR_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd_i | input | 1 | Asynchronous serial receive line, idles high; any transition arms |
| vsync_i | input | 1 | Asynchronous frame sync; a rising edge triggers capture |
| smp_i | input | DATA_W | Video sample |
| smp_en_i | input | 1 | Sample present this cycle |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_waddr_o | output | ADDR_W | Buffer write address |
| buf_wdata_o | output | DATA_W | Buffer write data |
| buf_re_o | output | 1 | Buffer read request |
| buf_raddr_o | output | ADDR_W | Buffer read address |
| buf_rdata_i | input | DATA_W | Buffer read data, valid the cycle after `buf_re_o` |
| tx_byte_o | output | DATA_W | Byte to transmitter |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |

## Verification
Several complete frames are run with three sample-enable cadences: every cycle, alternate cycles, and two of every three cycles. These are crossed with three transmitter-ready cadences: always ready, alternating, and one ready cycle in four. Sparse enables separate address-per-write from address-per-cycle. Sparse ready separates handshake-driven address advance from free-running readout. The frames alternate arming by rising and falling receive-line edges. Half of them present a falling frame-sync edge while armed, which separates rising-edge triggering from any-edge triggering. Receive-line toggles are placed inside capture and dump, and a frame-sync edge is applied after each dump, which exposes any stray re-arming.

// File: rtl/fgc_pkg.sv
package fgc_pkg;

    typedef enum logic [1:0] {
        FGC_IDLE    = 2'd0,
        FGC_ARMED   = 2'd1,
        FGC_CAPTURE = 2'd2,
        FGC_DUMP    = 2'd3
    } fgc_state_e;

endpackage

// File: rtl/fgc_edge_sync.sv
// Two-flop synchroniser followed by a one-cycle edge pulse.
module fgc_edge_sync #(
    parameter bit RESET_LVL = 1'b0,
    parameter int EDGE_KIND = 0    // 0: either edge, 1: rising edge only
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.s1   = din;
        nxt_d.s2   = cur_q.s1;
        nxt_d.prev = cur_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{s1: RESET_LVL, s2: RESET_LVL, prev: RESET_LVL};
        end else begin
            cur_q <= nxt_d;
        end
    end

    generate
        if (EDGE_KIND == 1) begin : g_rise
            assign pulse_o = cur_q.s2 & ~cur_q.prev;
        end else begin : g_any
            assign pulse_o = cur_q.s2 ^ cur_q.prev;
        end
    endgenerate

endmodule

// File: rtl/fgc_ctrl.sv
// Sequencer: rest, armed, capture into buffer, dump through handshake.
module fgc_ctrl
    import fgc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_pulse,
    input  logic              trig_pulse,
    input  logic [DATA_W-1:0] smp,
    input  logic              smp_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              tx_ready,
    output fgc_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_en_o,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        fgc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic              pend;   // read issued, data returns this cycle
        logic              vld;    // byte held for transmitter
        logic [DATA_W-1:0] data;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  wr_en_d;
    logic  rd_en_d;

    always_comb begin
        nxt_d   = cur_q;
        wr_en_d = 1'b0;
        rd_en_d = 1'b0;
        unique case (cur_q.state)
            FGC_IDLE: begin
                if (arm_pulse) begin
                    nxt_d.state = FGC_ARMED;
                end
            end
            FGC_ARMED: begin
                if (trig_pulse) begin
                    nxt_d.state = FGC_CAPTURE;
                    nxt_d.addr  = '0;
                end
            end
            FGC_CAPTURE: begin
                if (smp_en) begin
                    wr_en_d = 1'b1;
                    if (cur_q.addr == LAST_ADDR) begin
                        nxt_d.state = FGC_DUMP;
                        nxt_d.addr  = '0;
                        nxt_d.pend  = 1'b0;
                        nxt_d.vld   = 1'b0;
                    end else begin
                        nxt_d.addr = cur_q.addr + 1'b1;
                    end
                end
            end
            FGC_DUMP: begin
                if (!cur_q.pend && !cur_q.vld) begin
                    rd_en_d    = 1'b1;
                    nxt_d.pend = 1'b1;
                end
                if (cur_q.pend) begin
                    nxt_d.pend = 1'b0;
                    nxt_d.vld  = 1'b1;
                    nxt_d.data = rd_data;
                end
                if (cur_q.vld && tx_ready) begin
                    nxt_d.vld = 1'b0;
                    if (cur_q.addr == LAST_ADDR) begin
                        nxt_d.state = FGC_IDLE;
                        nxt_d.addr  = '0;
                    end else begin
                        nxt_d.addr = cur_q.addr + 1'b1;
                    end
                end
            end
            default: nxt_d.state = FGC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: FGC_IDLE, addr: '0, pend: 1'b0, vld: 1'b0, data: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o    = cur_q.state;
    assign addr_o     = cur_q.addr;
    assign wr_en_o    = wr_en_d;
    assign wr_data_o  = smp;
    assign rd_en_o    = rd_en_d;
    assign tx_valid_o = cur_q.vld;
    assign tx_data_o  = cur_q.data;

endmodule

// File: rtl/frame_grab_ctrl.sv
module frame_grab_ctrl
    import fgc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd_i,
    input  logic              vsync_i,
    input  logic [DATA_W-1:0] smp_i,
    input  logic              smp_en_i,
    output logic              buf_we_o,
    output logic [ADDR_W-1:0] buf_waddr_o,
    output logic [DATA_W-1:0] buf_wdata_o,
    output logic              buf_re_o,
    output logic [ADDR_W-1:0] buf_raddr_o,
    input  logic [DATA_W-1:0] buf_rdata_i,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i
);

    logic              arm_pulse_w;
    logic              trig_pulse_w;
    fgc_state_e        state_w;
    logic [ADDR_W-1:0] addr_w;

    fgc_edge_sync #(.RESET_LVL(1'b1), .EDGE_KIND(0)) u_rx_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (rxd_i),
        .pulse_o (arm_pulse_w)
    );

    fgc_edge_sync #(.RESET_LVL(1'b0), .EDGE_KIND(1)) u_vs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (vsync_i),
        .pulse_o (trig_pulse_w)
    );

    fgc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_pulse  (arm_pulse_w),
        .trig_pulse (trig_pulse_w),
        .smp        (smp_i),
        .smp_en     (smp_en_i),
        .rd_data    (buf_rdata_i),
        .tx_ready   (tx_ready_i),
        .state_o    (state_w),
        .addr_o     (addr_w),
        .wr_en_o    (buf_we_o),
        .wr_data_o  (buf_wdata_o),
        .rd_en_o    (buf_re_o),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_byte_o)
    );

    assign buf_waddr_o = addr_w;
    assign buf_raddr_o = addr_w;

endmodule

// File: rtl/fgc_checker.sv
module fgc_checker
    import fgc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input fgc_state_e        state,
    input logic              buf_we_o,
    input logic [ADDR_W-1:0] buf_waddr_o,
    input logic              buf_re_o,
    input logic [ADDR_W-1:0] buf_raddr_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic [DATA_W-1:0] tx_byte_o
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    AST_REST_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FGC_IDLE) |=> (state == FGC_IDLE || state == FGC_ARMED)); // R3

    AST_CAPTURE_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == FGC_CAPTURE) |-> (buf_waddr_o == '0)); // R5

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we_o && buf_waddr_o != LAST_ADDR) |=> (buf_waddr_o == $past(buf_waddr_o) + 1'b1)); // R5

    AST_NO_WRITE_IN_DUMP: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we_o && (buf_re_o || tx_valid_o))); // R6

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o) && $stable(buf_raddr_o))); // R8

    AST_RD_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && buf_raddr_o != LAST_ADDR) |=> (buf_raddr_o == $past(buf_raddr_o) + 1'b1)); // R8

    AST_READ_THEN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        buf_re_o |=> !tx_valid_o); // R8

    AST_REST_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && tx_ready_i && buf_raddr_o == LAST_ADDR) |=> (state == FGC_IDLE && !tx_valid_o)); // R9

endmodule

bind frame_grab_ctrl fgc_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fgc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state_w),
    .buf_we_o    (buf_we_o),
    .buf_waddr_o (buf_waddr_o),
    .buf_re_o    (buf_re_o),
    .buf_raddr_o (buf_raddr_o),
    .tx_valid_o  (tx_valid_o),
    .tx_ready_i  (tx_ready_i),
    .tx_byte_o   (tx_byte_o)
);

// File: tb/sim_frame_grab_ctrl.sv
module sim_frame_grab_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rxd_i;
    logic              vsync_i;
    logic [DATA_W-1:0] smp_i;
    logic              smp_en_i;
    logic              buf_we_o;
    logic [ADDR_W-1:0] buf_waddr_o;
    logic [DATA_W-1:0] buf_wdata_o;
    logic              buf_re_o;
    logic [ADDR_W-1:0] buf_raddr_o;
    logic [DATA_W-1:0] buf_rdata_i;
    logic [DATA_W-1:0] tx_byte_o;
    logic              tx_valid_o;
    logic              tx_ready_i;

    logic [DATA_W-1:0] mem [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    frame_grab_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u0 (
        .clk (clk), .rst_n (rst_n), .rxd_i (rxd_i), .vsync_i (vsync_i),
        .smp_i (smp_i), .smp_en_i (smp_en_i),
        .buf_we_o (buf_we_o), .buf_waddr_o (buf_waddr_o), .buf_wdata_o (buf_wdata_o),
        .buf_re_o (buf_re_o), .buf_raddr_o (buf_raddr_o), .buf_rdata_i (buf_rdata_i),
        .tx_byte_o (tx_byte_o), .tx_valid_o (tx_valid_o), .tx_ready_i (tx_ready_i)
    );

    // External buffer model: synchronous write, one-cycle read latency.
    always @(posedge clk) begin
        if (buf_we_o) mem[buf_waddr_o] <= buf_wdata_o;
        if (buf_re_o) buf_rdata_i <= mem[buf_raddr_o];
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [DATA_W-1:0] sval(input int run, input int idx);
        return DATA_W'((idx * 7 + run * 29 + 3) & 8'hFF);
    endfunction

    function automatic bit en_pat(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return ~c[0];
            default: return (c % 3) != 2;
        endcase
    endfunction

    function automatic bit rdy_pat(input int mode, input int c);
        case (mode)
            0: return 1'b1;
            1: return c[0];
            default: return (c % 4) == 3;
        endcase
    endfunction

    // Hold smp_en high for n cycles and require no write strobe.
    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            smp_en_i = 1'b1;
            #1;
            chk(buf_we_o == 1'b0, req, buf_we_o, 0);
            @(negedge clk);
        end
        smp_en_i = 1'b0;
    endtask

    task automatic run_frame(input int run, input int en_mode, input int rdy_mode, input bit fall_vs);
        int idx;
        int c;
        int b;
        bit was_high;
        tx_ready_i = 1'b0;
        if (fall_vs) begin
            vsync_i = 1'b1;              // rise while at rest: ignored
            quiet(5, "R4 rest vsync rise");
        end
        was_high = rxd_i;
        rxd_i = ~rxd_i;                  // arm
        quiet(4, was_high ? "R3 arm by falling rxd" : "R3 arm by rising rxd");
        if (fall_vs) begin
            vsync_i = 1'b0;              // falling edge while armed: ignored
            quiet(5, "R4 armed vsync fall");
        end
        // trigger with latency check
        vsync_i  = 1'b1;
        smp_en_i = 1'b1;
        #1;
        chk(buf_we_o == 1'b0, "R2 latency edge k-1", buf_we_o, 0);
        @(negedge clk);
        #1;
        chk(buf_we_o == 1'b0, "R2 latency edge k", buf_we_o, 0);
        @(negedge clk);
        #1;
        chk(buf_we_o == 1'b0, "R2 latency edge k+1", buf_we_o, 0);
        @(negedge clk);
        // capture
        idx = 0;
        c   = 0;
        while (idx < DEPTH && c < 20 * DEPTH) begin
            smp_en_i = en_pat(en_mode, c);
            smp_i    = sval(run, idx);
            if (c == 1) rxd_i = ~rxd_i;  // ignored during capture
            if (c == 3) vsync_i = 1'b0;
            #1;
            chk(buf_we_o == smp_en_i, "R5 write strobe", buf_we_o, smp_en_i);
            chk(buf_waddr_o == ADDR_W'(idx), "R5 write address", buf_waddr_o, idx);
            if (smp_en_i) begin
                chk(buf_wdata_o == sval(run, idx), "R5 write data", buf_wdata_o, sval(run, idx));
                idx++;
            end
            @(negedge clk);
            c++;
        end
        // dump
        smp_en_i = 1'b1;
        b = 0;
        c = 0;
        while (b < DEPTH && c < 20 * DEPTH) begin
            tx_ready_i = rdy_pat(rdy_mode, c);
            if (b == 0 && c == 0) rxd_i = ~rxd_i;  // ignored during dump
            #1;
            chk(buf_we_o == 1'b0, "R6 no write in dump", buf_we_o, 0);
            chk(buf_raddr_o == ADDR_W'(b), "R8 read address", buf_raddr_o, b);
            if (tx_valid_o) begin
                chk(tx_byte_o == sval(run, b), "R10 dumped byte", tx_byte_o, sval(run, b));
                if (tx_ready_i) b++;
            end
            @(negedge clk);
            c++;
        end
        chk(b == DEPTH, "R8 dump completes", b, DEPTH);
        tx_ready_i = 1'b0;
        smp_en_i   = 1'b0;
        #1;
        chk(tx_valid_o == 1'b0 && buf_re_o == 1'b0, "R9 rest after last byte",
            {tx_valid_o, buf_re_o}, 0);
        @(negedge clk);
        // not re-armed by rxd activity during capture/dump
        vsync_i = 1'b1;
        quiet(4, "R7 no rearm");
        vsync_i = 1'b0;
        quiet(4, "R7 no rearm");
    endtask

    initial begin
        rst_n      = 1'b0;
        rxd_i      = 1'b1;
        vsync_i    = 1'b0;
        smp_i      = '0;
        smp_en_i   = 1'b1;
        tx_ready_i = 1'b1;
        repeat (4) @(negedge clk);
        #1;
        chk(buf_we_o == 1'b0, "R1 reset write strobe", buf_we_o, 0);
        chk(buf_re_o == 1'b0, "R1 reset read strobe", buf_re_o, 0);
        chk(tx_valid_o == 1'b0, "R1 reset valid", tx_valid_o, 0);
        chk(buf_waddr_o == '0 && buf_raddr_o == '0, "R1 reset addresses",
            int'(buf_waddr_o) + int'(buf_raddr_o), 0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet(4, "R1 rest after reset");
        run_frame(0, 0, 0, 1'b0);
        run_frame(1, 1, 1, 1'b1);
        run_frame(2, 2, 2, 1'b0);
        run_frame(3, 0, 2, 1'b1);
        run_frame(4, 2, 1, 1'b0);
        run_frame(5, 1, 0, 1'b1);   // R9 repeated arming
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule